// File: doc/BRIEF.md
# Adjustable PTP Time-of-Day Counter

This block holds a precision-time-protocol clock made of three registers: whole seconds, nanoseconds within the second, and a fraction of a nanosecond in steps of 2^-32 ns. The clock moves forward once on every reference clock edge. The amount it adds is a fixed-point increment: the nominal reference period in nanoseconds, plus a signed trim. The clock shows no negative time. The seconds register is 32 bits wide and wraps to zero.

Software drives one command port, made of a strobe, a 3-bit opcode and a 64-bit data word. With it, software can:
- load an absolute time;
- shift the time by a signed number of nanoseconds;
- set a permanent rate trim;
- set a temporary rate trim that holds for a set number of cycles and then drops back to the permanent trim.

A load or a shift in the same cycle as the normal advance also includes that cycle's increment, so no cycle is lost. The block outputs the current time and the increment in force.

Top module: `ptp_tod_counter`

## Requirements
- R1: During and right after reset, seconds, nanoseconds and fraction are all zero, and `incr_o` equals NOM_NS·2^32. No temporary trim is active.
- R2: On each edge with no command, the time grows by `incr_o`, where `incr_o` is a fixed-point value with 32 fraction bits. A carry out of the fraction adds 1 ns. When nanoseconds reach 10^9, the block removes 10^9 and adds one second. `tod_ns_o` stays below 10^9 at all times.
- R3: Opcode 1 (load) takes the seconds from data[63:32] and the nanoseconds from data[29:0], which must be below 10^9. It clears the fraction. The result already includes that edge's increment.
- R4: Opcode 2 (shift) adds data[31:0] to the time as a two's-complement number of nanoseconds, together with that edge's increment. Its magnitude must be below 10^9. A result below zero borrows one second and adds 10^9.
- R5: Opcode 3 stores data[31:0] as the signed permanent trim, in units of 2^-32 ns. The edge that takes the command still uses the old increment. From then on, `incr_o` = NOM_NS·2^32 + trim while no temporary trim is active.
- R6: Opcode 4 stores data[31:0] as a signed temporary trim and data[63:32] as a duration D. The next D increments after the command edge use the temporary trim, and then the permanent trim applies again. D = 0 starts nothing.
- R7: An opcode 4 that arrives while a temporary trim is active replaces that trim and restarts the count with the new D. An opcode 3 during an active trim changes only the permanent trim, which shows once the temporary period ends.
- R8: When the seconds register carries past 2^32−1, it wraps to zero.
- R9: Opcodes 0, 5, 6 and 7, and any cycle with `cmd_valid` low, leave the time and the increment exactly as a plain advance would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 64 | Command operand |
| tod_sec_o | output | 32 | Seconds |
| tod_ns_o | output | 30 | Nanoseconds within the second |
| tod_frac_o | output | 32 | Fraction of a nanosecond, units 2^-32 ns |
| incr_o | output | INT_W+32 | Per-cycle increment in force, 32 fraction bits |

## Verification
Runs of free advance with positive, negative and zero trims show whether the fraction carry and the 10^9 rollover are handled correctly over many cycles. Loads placed a few nanoseconds below a second, and at the last second before the 32-bit wrap, isolate the carry into seconds and the wrap. Negative shifts that cross zero test the borrow path. Temporary trims of length 0, 3 and a restarted one separate off-by-one counting errors from errors in reverting to the permanent trim. Random command mixes, including the unused opcodes, show whether a command disturbs anything it should not.

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
  parameter int NOM_NS = 8,
  parameter int INT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [63:0]          cmd_data,
  output logic [31:0]          tod_sec_o,
  output logic [29:0]          tod_ns_o,
  output logic [31:0]          tod_frac_o,
  output logic [INT_W+31:0]    incr_o
);
  localparam int INC_W = INT_W + 32;
  localparam logic [INC_W-1:0] NOM_FX = INC_W'(NOM_NS) << 32;
  localparam logic signed [33:0] BILLION = 34'sd1000000000;
  localparam logic signed [33:0] TWO_BILLION = 34'sd2000000000;
  localparam logic [2:0] OP_LOAD = 3'd1, OP_SHIFT = 3'd2, OP_RATE = 3'd3, OP_TEMP = 3'd4;

  logic [31:0]        sec_q, frac_q, temp_left_q;
  logic [29:0]        ns_q;
  logic signed [31:0] perm_rate_q, temp_rate_q;
  logic               started_q;

  wire is_load  = cmd_valid && cmd_op == OP_LOAD;
  wire is_shift = cmd_valid && cmd_op == OP_SHIFT;
  wire is_rate  = cmd_valid && cmd_op == OP_RATE;
  wire is_temp  = cmd_valid && cmd_op == OP_TEMP;
  wire temp_on  = temp_left_q != 32'd0;

  wire signed [31:0] rate_eff = temp_on ? temp_rate_q : perm_rate_q;
  assign incr_o = NOM_FX + {{INT_W{rate_eff[31]}}, rate_eff};

  wire [31:0] base_sec  = is_load ? cmd_data[63:32] : sec_q;
  wire [29:0] base_ns   = is_load ? cmd_data[29:0]  : ns_q;
  wire [31:0] base_frac = is_load ? 32'd0           : frac_q;

  wire [32:0] frac_sum = {1'b0, base_frac} + {1'b0, incr_o[31:0]};

  wire signed [33:0] shift_v = is_shift ? $signed({{2{cmd_data[31]}}, cmd_data[31:0]}) : 34'sd0;
  wire signed [33:0] int_v   = $signed(34'(incr_o[INC_W-1:32]));
  wire signed [33:0] ns_sum  = $signed({4'b0, base_ns}) + int_v
                             + $signed({33'b0, frac_sum[32]}) + shift_v;

  logic [31:0] sec_n;
  logic [33:0] ns_n;
  always_comb begin
    if (ns_sum >= TWO_BILLION) begin
      ns_n  = 34'(ns_sum - TWO_BILLION);
      sec_n = base_sec + 32'd2;
    end else if (ns_sum >= BILLION) begin
      ns_n  = 34'(ns_sum - BILLION);
      sec_n = base_sec + 32'd1;
    end else if (ns_sum < 0) begin
      ns_n  = 34'(ns_sum + BILLION);
      sec_n = base_sec - 32'd1;
    end else begin
      ns_n  = 34'(ns_sum);
      sec_n = base_sec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q       <= '0;
      ns_q        <= '0;
      frac_q      <= '0;
      perm_rate_q <= '0;
      temp_rate_q <= '0;
      temp_left_q <= '0;
      started_q   <= 1'b0;
    end else begin
      started_q <= 1'b1;
      sec_q     <= sec_n;
      ns_q      <= ns_n[29:0];
      frac_q    <= frac_sum[31:0];
      if (is_rate) perm_rate_q <= $signed(cmd_data[31:0]);
      if (is_temp) begin
        temp_rate_q <= $signed(cmd_data[31:0]);
        temp_left_q <= cmd_data[63:32];
      end else if (temp_on) begin
        temp_left_q <= temp_left_q - 32'd1;
      end
    end
  end

  assign tod_sec_o  = sec_q;
  assign tod_ns_o   = ns_q;
  assign tod_frac_o = frac_q;

  AST_NS_BELOW_BILLION: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> tod_ns_o < 30'd1000000000); // R2

  AST_SEC_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    started_q && !is_load && !is_shift |=>
      (tod_sec_o == $past(tod_sec_o) || tod_sec_o == $past(tod_sec_o) + 32'd1)); // R8

  AST_LOAD_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    started_q && is_load |=> tod_frac_o == $past(incr_o[31:0])); // R3

  AST_RATE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    started_q && !is_rate && !is_temp && !temp_on |=> $stable(incr_o)); // R5

  AST_TEMP_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
    started_q && temp_left_q == 32'd1 && !is_temp && !is_rate |=>
      incr_o == NOM_FX + {{INT_W{perm_rate_q[31]}}, perm_rate_q}); // R6
endmodule

// File: tb/test_ptp_tod_counter.sv
module test_ptp_tod_counter;
  localparam int NOM_NS = 8;
  localparam int INT_W  = 8;
  localparam longint BIL = 1000000000;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [63:0] cmd_data = '0;
  logic [31:0] tod_sec_o, tod_frac_o;
  logic [29:0] tod_ns_o;
  logic [INT_W+31:0] incr_o;

  ptp_tod_counter #(.NOM_NS(NOM_NS), .INT_W(INT_W)) i_ptp_tod_counter (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .tod_sec_o(tod_sec_o), .tod_ns_o(tod_ns_o), .tod_frac_o(tod_frac_o), .incr_o(incr_o));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  longint m_sec = 0, m_ns = 0, m_frac = 0, m_cnt = 0;
  int m_perm = 0, m_temp = 0;

  function automatic longint eff_incr();
    return (longint'(NOM_NS) <<< 32) + longint'(m_cnt > 0 ? m_temp : m_perm);
  endfunction

  function automatic void model(input bit v, input logic [2:0] op, input logic [63:0] d);
    longint inc = eff_incr();
    longint s = m_sec, n = m_ns, f = m_frac;
    if (v && op == 3'd1) begin s = longint'(d[63:32]); n = longint'(d[29:0]); f = 0; end
    f = f + (inc & 64'hFFFF_FFFF);
    n = n + (inc >>> 32) + (f >>> 32);
    f = f & 64'hFFFF_FFFF;
    if (v && op == 3'd2) n = n + longint'($signed(d[31:0]));
    while (n >= BIL) begin n -= BIL; s++; end
    while (n < 0) begin n += BIL; s--; end
    m_sec = s & 64'hFFFF_FFFF; m_ns = n; m_frac = f;
    if (v && op == 3'd4) begin m_temp = $signed(d[31:0]); m_cnt = longint'(d[63:32]); end
    else if (m_cnt > 0) m_cnt--;
    if (v && op == 3'd3) m_perm = $signed(d[31:0]);
  endfunction

  task automatic check(input string tag);
    longint inc = eff_incr();
    checks++;
    if (longint'(tod_sec_o) != m_sec || longint'(tod_ns_o) != m_ns ||
        longint'(tod_frac_o) != m_frac || longint'(incr_o) != inc) begin
      errors++;
      $display("FAIL %s: got sec=%0d ns=%0d frac=%0d inc=%0h exp sec=%0d ns=%0d frac=%0d inc=%0h",
               tag, tod_sec_o, tod_ns_o, tod_frac_o, incr_o, m_sec, m_ns, m_frac, inc);
    end
  endtask

  task automatic cyc(input bit v, input logic [2:0] op, input logic [63:0] d, input string tag);
    cmd_valid = v; cmd_op = op; cmd_data = d;
    @(posedge clk);
    model(v, op, d);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 64'd0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1588));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1");
    idle(10, "R2");
    cyc(1'b1, 3'd1, {32'd5, 32'd999_999_990}, "R3");
    idle(2, "R2");
    cyc(1'b1, 3'd1, {32'hFFFF_FFFF, 32'd999_999_996}, "R8");
    idle(2, "R8");
    cyc(1'b1, 3'd1, {32'd10, 32'd50}, "R3");
    cyc(1'b1, 3'd2, 64'(-32'sd100), "R4");
    cyc(1'b1, 3'd2, 64'(32'sd999_999_999), "R4");
    cyc(1'b1, 3'd2, 64'(-32'sd999_999_999), "R4");
    cyc(1'b1, 3'd3, 64'(32'h4000_0000), "R5");
    idle(4, "R5");
    cyc(1'b1, 3'd3, 64'(-32'sd3), "R5");
    idle(3, "R5");
    cyc(1'b1, 3'd4, {32'd3, 32'h8000_0000}, "R6");
    idle(5, "R6");
    cyc(1'b1, 3'd4, {32'd0, 32'h7FFF_FFFF}, "R6");
    idle(2, "R6");
    cyc(1'b1, 3'd4, {32'd5, 32'h1234_5678}, "R7");
    idle(2, "R7");
    cyc(1'b1, 3'd4, {32'd4, 32'hF000_0000}, "R7");
    cyc(1'b1, 3'd3, 64'(32'h0000_0100), "R7");
    idle(6, "R7");
    for (int op = 5; op < 8; op++) cyc(1'b1, 3'(op), 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    cyc(1'b1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      logic [63:0] d;
      bit v = ($urandom_range(0, 9) < 3);
      case (op)
        3'd1: d = {$urandom(), 32'($urandom_range(0, 999_999_999))};
        3'd2: d = 64'(32'($urandom_range(0, 1_999_999_998)) - 32'd999_999_999);
        3'd4: d = {32'($urandom_range(0, 20)), $urandom()};
        default: d = {$urandom(), $urandom()};
      endcase
      cyc(v, op, d, v && op == 3'd1 ? "R3" : v && op == 3'd2 ? "R4" :
                    v && op == 3'd3 ? "R5" : v && op == 3'd4 ? "R6" : "R2");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule